// File: doc/BRIEF.md
# Message Bus Register Bridge

This block gives a host access to a small internal register file through two 32-bit host windows. One window takes a control word and the other holds data. The control word carries an opcode, a target port number, a register offset and four byte-lane enables. Writing it starts a transaction in either direction. A read opcode copies the addressed target register into the data window. A write opcode pushes whatever the data window already holds into the target register, so the data must be staged before the control word is written.

One target port sits behind the bridge. It holds six 32-bit range registers, arranged as low/high pairs for three regions. A command with an unknown opcode, a foreign port or an unmapped offset leaves every target register untouched and raises a sticky error flag. If such a command was a read, it also clears the data window. Host reads are combinational from the stored state, and a command takes effect at the clock edge that accepts the control write.

Top module: `msgbus_bridge`

## Requirements
- R1: After reset, the control window, the data window, the error flag and all six range registers are zero.
- R2: Control word fields are opcode in bits 31:24, port in bits 23:16, offset in bits 15:8 and byte enables in bits 7:4. A control write at host offset 0xD0 with opcode 0xD0, port 0x3 and an offset from 0x10 to 0x15 loads that register into the data window at host offset 0xD4.
- R3: A control write with opcode 0xE0, port 0x3, a mapped offset and byte enables 0xF copies the full data window into the addressed register.
- R4: On a write command, enable bit 4+k of the control word gates byte lane k (data bits 8k+7:8k). Disabled lanes keep their value, and enables of 0x0 change nothing.
- R5: A read command returns all 32 bits whatever its byte enables are.
- R6: An opcode other than 0xD0 or 0xE0 changes no range register and leaves the data window unchanged, and it sets the error flag.
- R7: A port other than 0x3, or an offset outside 0x10 to 0x15, changes no range register and sets the error flag. For a read opcode it also loads zero into the data window.
- R8: The error flag stays set until reset. Later valid commands do not clear it.
- R9: A host read of the data window in the same cycle as a read command returns the previous value. The new value appears from the next cycle.
- R10: A host read at 0xD0 returns the last control word written. Host reads at any other offset except 0xD4 return zero, and host writes there change nothing.
- R11: The six offsets select six distinct registers, and no offset aliases another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_waddr | input | 8 | Host write offset |
| host_wdata | input | 32 | Host write data |
| host_raddr | input | 8 | Host read offset |
| host_rdata | output | 32 | Host read data, combinational |
| err_flag | output | 1 | Sticky command error |

## Verification
The bench aims at these corner cases:

- Partial byte enables: a bridge that ignored them would overwrite whole words. The bench uses sparse and empty lane patterns.
- Offsets just outside the mapped range (0x0F and 0x16): a loose range check would alias onto a live register.
- Read and write at every offset: a wrong index decode would make the pairs shadow each other.
- Same-cycle read of the data window during a read command: a design that forwarded the result would return the new value one cycle early.
- Error flag after a bad command: a design that did not hold it would let a later good command clear it.
- Read with a bad target: a design that kept stale data would not return zero.

// File: rtl/msgbus_pkg.sv
// Package: shared command layout and encodings for the message bus bridge.
// Assumes a 32-bit control word with four byte-lane enables.
package msgbus_pkg;

    localparam logic [7:0] OPC_READ  = 8'hD0;
    localparam logic [7:0] OPC_WRITE = 8'hE0;

    // Control word as the host writes it (field positions are decoded).
    typedef struct packed {
        logic [7:0] opcode;
        logic [7:0] port;
        logic [7:0] offset;
        logic [3:0] be;
        logic [3:0] rsvd;
    } cmd_word_t;

endpackage

// File: rtl/msgbus_cmd_decode.sv
// Module: msgbus_cmd_decode
// Classifies a control word into a read, a write or an error, and gives
// the register index. Purely combinational. Assumes the mapped registers
// are contiguous from BASE_OFFSET.
module msgbus_cmd_decode #(
    parameter int         NUM_REGS    = 6,
    parameter logic [7:0] PORT_ID     = 8'h03,
    parameter logic [7:0] BASE_OFFSET = 8'h10,
    localparam int        IDX_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  msgbus_pkg::cmd_word_t cmd,
    input  logic                  fire,
    output logic                  rd_go,
    output logic                  wr_go,
    output logic                  bad_go,
    output logic                  rd_zero,
    output logic                  opc_bad,
    output logic [IDX_W-1:0]      idx,
    output logic [3:0]            be
);
    import msgbus_pkg::*;

    logic [7:0] rel;
    logic       is_rd, is_wr, target_ok;

    // Field classification: opcode kind, port match and offset range.
    always_comb begin
        rel       = cmd.offset - BASE_OFFSET;
        is_rd     = (cmd.opcode == OPC_READ);
        is_wr     = (cmd.opcode == OPC_WRITE);
        target_ok = (cmd.port == PORT_ID) && (cmd.offset >= BASE_OFFSET)
                    && (rel < 8'(NUM_REGS));
        idx       = rel[IDX_W-1:0];
        be        = cmd.be;
    end

    // Qualified strobes, valid only while the control window is written.
    always_comb begin
        opc_bad = fire && !is_rd && !is_wr;
        rd_go   = fire && is_rd && target_ok;
        wr_go   = fire && is_wr && target_ok;
        rd_zero = fire && is_rd && !target_ok;
        bad_go  = opc_bad || (fire && (is_rd || is_wr) && !target_ok);
    end

endmodule

// File: rtl/msgbus_range_regs.sv
// Module: msgbus_range_regs
// The target register file: NUM_REGS words with per-lane write enables
// and an asynchronous read port. Assumes DW is a multiple of 8.
module msgbus_range_regs #(
    parameter int  NUM_REGS = 6,
    parameter int  DW       = 32,
    localparam int LANES    = DW / 8,
    localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [LANES-1:0] wr_be,
    input  logic [DW-1:0]    wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_data
);

    logic [NUM_REGS-1:0][DW-1:0] regs;
    logic [NUM_REGS-1:0]         sel;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // Word select for register g.
        assign sel[g] = wr_en && (int'(wr_idx) == g);

        for (genvar l = 0; l < LANES; l++) begin : g_lane
            // Byte lane l of register g: reset or gated update.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[g][l*8 +: 8] <= '0;
                else if (sel[g] && wr_be[l])
                    regs[g][l*8 +: 8] <= wr_data[l*8 +: 8];
            end
        end
    end

    // Read mux, guarded against indices past the last register.
    always_comb begin
        rd_data = (int'(rd_idx) < NUM_REGS) ? regs[rd_idx] : '0;
    end

    // R11
    lane_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs));

endmodule

// File: rtl/msgbus_bridge.sv
// Module: msgbus_bridge (top)
// Host-facing bridge: holds the control and data windows and the sticky
// error flag, and drives the decoder and the target register file.
// Assumes one host write port and a separate combinational read port.
module msgbus_bridge #(
    parameter int         NUM_REGIONS = 3,
    parameter int         DW          = 32,
    parameter logic [7:0] CTRL_ADDR   = 8'hD0,
    parameter logic [7:0] DATA_ADDR   = 8'hD4,
    parameter logic [7:0] PORT_ID     = 8'h03,
    parameter logic [7:0] BASE_OFFSET = 8'h10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic [7:0]    host_waddr,
    input  logic [DW-1:0] host_wdata,
    input  logic [7:0]    host_raddr,
    output logic [DW-1:0] host_rdata,
    output logic          err_flag
);
    import msgbus_pkg::*;

    localparam int NUM_REGS = 2 * NUM_REGIONS;
    localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [DW-1:0]    ctrl_q, data_q, rd_data;
    logic             err_q, ctrl_fire, data_fire;
    logic             rd_go, wr_go, bad_go, rd_zero, opc_bad;
    logic [IDX_W-1:0] idx;
    logic [3:0]       be;

    // Host write strobes per window.
    assign ctrl_fire = host_wr && (host_waddr == CTRL_ADDR);
    assign data_fire = host_wr && (host_waddr == DATA_ADDR);

    msgbus_cmd_decode #(
        .NUM_REGS(NUM_REGS), .PORT_ID(PORT_ID), .BASE_OFFSET(BASE_OFFSET)
    ) u_dec (
        .cmd(cmd_word_t'(host_wdata)), .fire(ctrl_fire),
        .rd_go(rd_go), .wr_go(wr_go), .bad_go(bad_go),
        .rd_zero(rd_zero), .opc_bad(opc_bad), .idx(idx), .be(be)
    );

    msgbus_range_regs #(.NUM_REGS(NUM_REGS), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_go), .wr_idx(idx), .wr_be(be), .wr_data(data_q),
        .rd_idx(idx), .rd_data(rd_data)
    );

    // Control window: keeps the last control word written.
    always_ff @(posedge clk) begin
        if (!rst_n)         ctrl_q <= '0;
        else if (ctrl_fire) ctrl_q <= host_wdata;
    end

    // Data window: a read result or a zeroed bad read wins over host data.
    always_ff @(posedge clk) begin
        if (!rst_n)         data_q <= '0;
        else if (rd_go)     data_q <= rd_data;
        else if (rd_zero)   data_q <= '0;
        else if (data_fire) data_q <= host_wdata;
    end

    // Sticky error flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      err_q <= 1'b0;
        else if (bad_go) err_q <= 1'b1;
    end

    // Host read mux over the two windows.
    always_comb begin
        if (host_raddr == CTRL_ADDR)      host_rdata = ctrl_q;
        else if (host_raddr == DATA_ADDR) host_rdata = data_q;
        else                              host_rdata = '0;
    end

    assign err_flag = err_q;

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    // R2
    read_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> (data_q == $past(rd_data)));

    // R6
    bad_op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        opc_bad |=> ($stable(data_q) && err_q));

    // R7
    bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_zero |=> (data_q == '0 && err_q));

endmodule

// File: tb/msgbus_bridge_tb.sv
module msgbus_bridge_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_waddr = '0;
    logic [31:0] host_wdata = '0;
    logic [7:0]  host_raddr = '0;
    logic [31:0] host_rdata;
    logic        err_flag;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] model [6];

    always #5 clk = ~clk;

    msgbus_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_waddr(host_waddr),
        .host_wdata(host_wdata), .host_raddr(host_raddr),
        .host_rdata(host_rdata), .err_flag(err_flag)
    );

    function automatic logic [31:0] mk(input logic [7:0] op, input logic [7:0] pt,
                                       input logic [7:0] off, input logic [3:0] be);
        return {op, pt, off, be, 4'h0};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_waddr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_waddr = 8'h00; host_wdata = '0;
    endtask

    task automatic hread(input logic [7:0] a, output logic [31:0] d);
        host_raddr = a;
        #1 d = host_rdata;
    endtask

    task automatic reg_read(input int i, input logic [3:0] be, output logic [31:0] d);
        hwrite(8'hD0, mk(8'hD0, 8'h03, 8'(8'h10 + i), be));
        hread(8'hD4, d);
    endtask

    task automatic reg_write(input int i, input logic [31:0] v, input logic [3:0] be);
        hwrite(8'hD4, v);
        hwrite(8'hD0, mk(8'hE0, 8'h03, 8'(8'h10 + i), be));
        for (int l = 0; l < 4; l++)
            if (be[l]) model[i][l*8 +: 8] = v[l*8 +: 8];
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 6; i++) model[i] = '0;
    endtask

    task automatic check_all_regs(input string tag);
        logic [31:0] d;
        for (int i = 0; i < 6; i++) begin
            reg_read(i, 4'hF, d);
            check(tag, d, model[i]);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        hread(8'hD0, d); check("R1 ctrl window", d, 32'h0);
        hread(8'hD4, d); check("R1 data window", d, 32'h0);
        check("R1 err flag", {31'h0, err_flag}, 32'h0);
        check_all_regs("R1 range regs");
    endtask

    task automatic t_all_regs();
        for (int i = 0; i < 6; i++) reg_write(i, 32'hA5000000 | (32'(i) * 32'h01010101), 4'hF);
        check_all_regs("R2/R3/R11 write then read each offset");
        check("R8 err stays clear on valid traffic", {31'h0, err_flag}, 32'h0);
    endtask

    task automatic t_lanes();
        reg_write(2, 32'h11223344, 4'hF);
        reg_write(2, 32'hAABBCCDD, 4'h5);
        reg_write(3, 32'hCAFEF00D, 4'hF);
        reg_write(3, 32'h99999999, 4'hA);
        reg_write(4, 32'h0BADBEEF, 4'h0);
        check_all_regs("R4 byte lane merge");
    endtask

    task automatic t_read_be();
        logic [31:0] d;
        reg_read(3, 4'h0, d);
        check("R5 read ignores enables", d, model[3]);
    endtask

    task automatic t_bad_opcode();
        logic [31:0] d;
        do_reset();
        reg_write(1, 32'h13572468, 4'hF);
        hwrite(8'hD4, 32'h12345678);
        hwrite(8'hD0, mk(8'h55, 8'h03, 8'h11, 4'hF));
        check("R6 err set by bad opcode", {31'h0, err_flag}, 32'h1);
        hread(8'hD4, d); check("R6 data window kept", d, 32'h12345678);
        check_all_regs("R6 no reg change");
        check("R8 err held after valid traffic", {31'h0, err_flag}, 32'h1);
    endtask

    task automatic t_bad_target();
        logic [31:0] d;
        do_reset();
        reg_write(0, 32'hFEEDFACE, 4'hF);
        reg_write(5, 32'h01234567, 4'hF);
        reg_read(0, 4'hF, d);
        hwrite(8'hD0, mk(8'hD0, 8'h02, 8'h10, 4'hF));
        hread(8'hD4, d); check("R7 bad port read gives zero", d, 32'h0);
        check("R7 err set", {31'h0, err_flag}, 32'h1);
        hwrite(8'hD4, 32'hDEADDEAD);
        hwrite(8'hD0, mk(8'hE0, 8'h03, 8'h16, 4'hF));
        hwrite(8'hD4, 32'hDEADDEAD);
        hwrite(8'hD0, mk(8'hE0, 8'h03, 8'h0F, 4'hF));
        hwrite(8'hD4, 32'hDEADDEAD);
        hwrite(8'hD0, mk(8'hE0, 8'h04, 8'h12, 4'hF));
        check_all_regs("R7 no reg change on bad target");
        hwrite(8'hD0, mk(8'hD0, 8'h03, 8'h16, 4'hF));
        hread(8'hD4, d); check("R7 unmapped offset read zero", d, 32'h0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] d;
        reg_write(4, 32'h5A5AC3C3, 4'hF);
        hwrite(8'hD4, 32'h77770000);
        @(negedge clk);
        host_wr = 1'b1; host_waddr = 8'hD0; host_wdata = mk(8'hD0, 8'h03, 8'h14, 4'hF);
        host_raddr = 8'hD4;
        #1 check("R9 same-cycle read is old", host_rdata, 32'h77770000);
        @(negedge clk);
        host_wr = 1'b0; host_waddr = 8'h00; host_wdata = '0;
        hread(8'hD4, d);
        check("R9 next-cycle read is new", d, 32'h5A5AC3C3);
    endtask

    task automatic t_windows();
        logic [31:0] d;
        logic [31:0] cw;
        cw = mk(8'hD0, 8'h03, 8'h15, 4'h3);
        hwrite(8'hD0, cw);
        hread(8'hD0, d); check("R10 ctrl readback", d, cw);
        hwrite(8'h40, 32'hFFFFFFFF);
        hread(8'h40, d); check("R10 other offset reads zero", d, 32'h0);
        hread(8'hD0, d); check("R10 ctrl unchanged by stray write", d, cw);
        hread(8'hD4, d); check("R10 data unchanged by stray write", d, model[5]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_all_regs();
        t_lanes();
        t_read_be();
        t_bad_opcode();
        t_bad_target();
        t_same_cycle();
        t_windows();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule